// File: doc/BRIEF.md
# Bit-Band Alias Access Unit

This unit sits between a bus master port and a word-addressed memory or register slave. It recognises two alias windows, one paired with an SRAM band and one with a peripheral band. In each window every 32-bit alias word stands for a single bit of the paired band. The alias offset is split so that alias address = alias base + byte offset × 32 + bit-in-byte × 4. The target word is then band base + (byte offset rounded down to a multiple of 4), and the bit position in that word is (byte offset mod 4) × 8 + bit-in-byte.

When the CPU master reads an alias word, the unit fetches the target word and returns the selected bit as 0x0000_0000 or 0x0000_0001. When the CPU master writes an alias word, the unit runs a locked sequence. It reads the target word, replaces the one bit with bit 0 of the write data, and writes the whole word back. No other slave access can enter between the read and the write, and the upstream ready stays low until the write-back has finished. Any other master that touches an alias window gets an error response and the slave is never accessed. Every address outside the alias windows goes to the slave unchanged, whichever master sends it.

Upstream handshake: the master holds `req_i` and the request fields stable until `ready_o` pulses for one cycle. Downstream handshake: the unit holds `dreq_o` and the request fields until `dready_i` pulses for one cycle. On a read, `drdata_i` is valid in that same cycle.

Top module: `bb_alias_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `ready_o`, `err_o` and `dreq_o` are low.
- R2: An alias access at 0x2200_0000 + b×32 + k×4 (b < 2^20, k < 8) addresses the word 0x2000_0000 + (b & ~3). The bit it selects is (b mod 4)×8 + k.
- R3: The same mapping holds for the peripheral pair: alias base 0x4200_0000, band base 0x4000_0000.
- R4: A CPU alias write (master ID equal to `CPU_ID`) makes exactly two slave accesses to the target word, both with byte enables 4'hF. The first is a read. The second is a write of the word that was read, with only the selected bit replaced by `wdata_i[0]`. Write-data bits 31:1 and `be_i` have no effect, and the response data is zero.
- R5: A CPU alias read makes exactly one slave read of the target word. It returns 0x0000_0001 when the selected bit is set and 0x0000_0000 when it is clear.
- R6: During an alias write, `ready_o` stays low until the write-back completes. The write-back is the next slave access after the read, with the same address.
- R7: An alias access from any other master ID responds with `err_o`=1 and `rdata_o`=0 and makes no slave access. The band contents are unchanged afterwards.
- R8: An access outside both alias windows, from any master, makes one slave access with the same address, write flag, byte enables and write data. A read returns the slave word unchanged, and `err_o` stays 0.
- R9: `ready_o` is high for exactly one cycle per request, and `err_o` is high only together with `ready_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Upstream request, held until ready |
| we_i | input | 1 | Upstream write flag |
| addr_i | input | 32 | Upstream byte address |
| wdata_i | input | 32 | Upstream write data |
| be_i | input | 4 | Upstream byte enables |
| mst_id_i | input | MST_W | Master identifier of the request |
| rdata_o | output | 32 | Response read data |
| ready_o | output | 1 | One-cycle response strobe |
| err_o | output | 1 | Error response, valid with ready |
| dreq_o | output | 1 | Slave request |
| dwe_o | output | 1 | Slave write flag |
| daddr_o | output | 32 | Slave byte address |
| dwdata_o | output | 32 | Slave write data |
| dbe_o | output | 4 | Slave byte enables |
| drdata_i | input | 32 | Slave read data, valid with dready_i |
| dready_i | input | 1 | Slave completion strobe |

## Verification
Alias decoding and the master-ID gate act on the same request in the same cycle. Whether an alias address becomes a locked read-modify-write, a one-bit read or an error depends on both together. The bench provokes this collision with random master IDs against random alias addresses in both windows, and with directed error-then-read pairs on the same bit. Each outcome is judged by the response flags, by the exact list of slave accesses logged by the memory model, and by reading the bit back afterwards. A second overlap occurs inside the locked sequence: the slave completion of the read phase and the launch of the write-back fall on one edge. Random slave latency moves that edge, and the logged pair has to be a read followed by a write to the same word.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BIT_W  = $clog2(DATA_W);
  localparam int unsigned BE_W   = DATA_W / 8;
  localparam int unsigned NREG   = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS,
    ST_ARD,
    ST_RMW_RD,
    ST_RMW_WR,
    ST_RESP
  } state_e;
endpackage

// File: rtl/bb_region_dec.sv
module bb_region_dec import bb_pkg::*; #(
  parameter int unsigned BAND_AW    = 20,
  parameter logic [31:0] BAND_BASE  = 32'h2000_0000,
  parameter logic [31:0] ALIAS_BASE = 32'h2200_0000
) (
  input  logic [29:0]      waddr_i,
  output logic             hit_o,
  output logic [31:0]      tgt_o,
  output logic [BIT_W-1:0] bit_o
);
  localparam int unsigned ALIAS_AW = BAND_AW + BIT_W;

  assign hit_o = (waddr_i[29:ALIAS_AW-2] == ALIAS_BASE[31:ALIAS_AW]);
  // word index bits above the bit field give the band word
  assign tgt_o = BAND_BASE |
                 {{(32-BAND_AW){1'b0}}, waddr_i[ALIAS_AW-3:BIT_W], 2'b00};
  assign bit_o = waddr_i[BIT_W-1:0];
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge import bb_pkg::*; (
  input  logic [DATA_W-1:0] word_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic              val_i,
  output logic [DATA_W-1:0] word_o,
  output logic              bit_o
);
  always_comb begin
    word_o         = word_i;
    word_o[bit_i]  = val_i;
  end
  assign bit_o = word_i[bit_i];
endmodule

// File: rtl/bb_alias_unit.sv
module bb_alias_unit import bb_pkg::*; #(
  parameter int unsigned      MST_W      = 4,
  parameter logic [MST_W-1:0] CPU_ID     = '0,
  parameter int unsigned      BAND_AW    = 20,
  parameter logic [31:0]      SRAM_BAND  = 32'h2000_0000,
  parameter logic [31:0]      SRAM_ALIAS = 32'h2200_0000,
  parameter logic [31:0]      PERI_BAND  = 32'h4000_0000,
  parameter logic [31:0]      PERI_ALIAS = 32'h4200_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [31:0]       addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [MST_W-1:0]  mst_id_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              err_o,
  output logic              dreq_o,
  output logic              dwe_o,
  output logic [31:0]       daddr_o,
  output logic [DATA_W-1:0] dwdata_o,
  output logic [BE_W-1:0]   dbe_o,
  input  logic [DATA_W-1:0] drdata_i,
  input  logic              dready_i
);
  localparam logic [31:0] BAND_TAB  [NREG] = '{SRAM_BAND, PERI_BAND};
  localparam logic [31:0] ALIAS_TAB [NREG] = '{SRAM_ALIAS, PERI_ALIAS};

  logic [NREG-1:0]  reg_hit;
  logic [31:0]      reg_tgt [NREG];
  logic [BIT_W-1:0] reg_bit [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    bb_region_dec #(
      .BAND_AW   (BAND_AW),
      .BAND_BASE (BAND_TAB[r]),
      .ALIAS_BASE(ALIAS_TAB[r])
    ) u_dec (
      .waddr_i(addr_i[31:2]),
      .hit_o  (reg_hit[r]),
      .tgt_o  (reg_tgt[r]),
      .bit_o  (reg_bit[r])
    );
  end

  logic             a_hit;
  logic [31:0]      a_tgt;
  logic [BIT_W-1:0] a_bit;

  // lowest region index wins if windows were to overlap
  always_comb begin
    a_hit = 1'b0;
    a_tgt = '0;
    a_bit = '0;
    for (int r = NREG - 1; r >= 0; r--) begin
      if (reg_hit[r]) begin
        a_hit = 1'b1;
        a_tgt = reg_tgt[r];
        a_bit = reg_bit[r];
      end
    end
  end

  state_e            state_q;
  logic [31:0]       addr_q, tgt_q;
  logic              we_q, nbit_q, err_q;
  logic [DATA_W-1:0] wdata_q, word_q, rdata_q;
  logic [BE_W-1:0]   be_q;
  logic [BIT_W-1:0]  bit_q;

  logic [DATA_W-1:0] merged;
  logic              picked;

  bb_bit_merge u_merge (
    .word_i(drdata_i),
    .bit_i (bit_q),
    .val_i (nbit_q),
    .word_o(merged),
    .bit_o (picked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      tgt_q   <= '0;
      we_q    <= 1'b0;
      nbit_q  <= 1'b0;
      err_q   <= 1'b0;
      wdata_q <= '0;
      word_q  <= '0;
      rdata_q <= '0;
      be_q    <= '0;
      bit_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          addr_q  <= addr_i;
          we_q    <= we_i;
          wdata_q <= wdata_i;
          be_q    <= be_i;
          tgt_q   <= a_tgt;
          bit_q   <= a_bit;
          nbit_q  <= wdata_i[0];
          rdata_q <= '0;
          err_q   <= a_hit && (mst_id_i != CPU_ID);
          if (!a_hit)                   state_q <= ST_PASS;
          else if (mst_id_i != CPU_ID)  state_q <= ST_RESP;
          else if (we_i)                state_q <= ST_RMW_RD;
          else                          state_q <= ST_ARD;
        end
        ST_PASS: if (dready_i) begin
          rdata_q <= we_q ? '0 : drdata_i;
          state_q <= ST_RESP;
        end
        ST_ARD: if (dready_i) begin
          rdata_q <= {{(DATA_W-1){1'b0}}, picked};
          state_q <= ST_RESP;
        end
        ST_RMW_RD: if (dready_i) begin
          word_q  <= merged;
          state_q <= ST_RMW_WR;
        end
        ST_RMW_WR: if (dready_i) state_q <= ST_RESP;
        ST_RESP:   state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  logic in_pass;
  assign in_pass = (state_q == ST_PASS);

  assign dreq_o   = in_pass || (state_q == ST_ARD) ||
                    (state_q == ST_RMW_RD) || (state_q == ST_RMW_WR);
  assign dwe_o    = (in_pass && we_q) || (state_q == ST_RMW_WR);
  assign daddr_o  = in_pass ? addr_q : tgt_q;
  assign dwdata_o = in_pass ? wdata_q : ((state_q == ST_RMW_WR) ? word_q : '0);
  assign dbe_o    = in_pass ? be_q : '1;

  assign ready_o  = (state_q == ST_RESP);
  assign err_o    = ready_o && err_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/bb_alias_unit_chk.sv
module bb_alias_unit_chk import bb_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              err_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              dreq_o,
  input logic              dwe_o,
  input logic [31:0]       daddr_o,
  input logic [DATA_W-1:0] dwdata_o,
  input logic [BE_W-1:0]   dbe_o,
  input logic [DATA_W-1:0] drdata_i,
  input logic              dready_i,
  input state_e            state_i
);
  logic [DATA_W-1:0] rd_hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rd_hold <= '0;
    else if (dreq_o && dready_i && !dwe_o) rd_hold <= drdata_i;
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!ready_o && !err_o && !dreq_o));

  // R9
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  // R7
  err_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ready_o && rdata_o == '0));

  // R6
  rmw_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RMW_RD && dready_i) |=>
      (dreq_o && dwe_o && !ready_o && dbe_o == '1 && daddr_o == $past(daddr_o)));

  // R4
  rmw_one_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RMW_WR) |-> ($countones(dwdata_o ^ rd_hold) <= 1));

  // R5
  alias_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ARD && dready_i) |=> (ready_o && rdata_o[DATA_W-1:1] == '0));
endmodule

bind bb_alias_unit bb_alias_unit_chk u_chk (.state_i(state_q), .*);

// File: tb/bb_alias_unit_test.sv
module bb_alias_unit_test;
  localparam int CLK_NS = 10;
  localparam logic [3:0] CPU = 4'd0;
  localparam logic [3:0] DMA = 4'd3;
  localparam logic [31:0] BAND  [2] = '{32'h2000_0000, 32'h4000_0000};
  localparam logic [31:0] ALIAS [2] = '{32'h2200_0000, 32'h4200_0000};
  localparam int K_AWR = 0, K_ARD = 1, K_AERR = 2, K_PASS = 3;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic [3:0]  be_i = '0, mst_id_i = '0;
  logic [31:0] rdata_o, daddr_o, dwdata_o;
  logic        ready_o, err_o, dreq_o, dwe_o;
  logic [3:0]  dbe_o;
  logic [31:0] drdata_i;
  logic        dready_i;

  int n_chk = 0, n_fail = 0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  bb_alias_unit uut (.*);

  // slave model and access log
  logic [31:0] dmem [logic [31:0]];
  logic [31:0] smem [logic [31:0]];
  int          op_cnt = 0;
  logic        op_we   [256];
  logic [31:0] op_addr [256];
  logic [31:0] op_data [256];
  logic [3:0]  op_be   [256];
  int          lat = 0;
  logic [31:0] w_tmp;

  function automatic logic [31:0] init_val(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  function automatic logic [31:0] be_merge(input logic [31:0] o, input logic [31:0] n,
                                           input logic [3:0] be);
    logic [31:0] r = o;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = n[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] dm_get(input logic [31:0] a);
    logic [31:0] k = {a[31:2], 2'b00};
    if (!dmem.exists(k)) dmem[k] = init_val(k);
    return dmem[k];
  endfunction

  function automatic logic [31:0] sm_get(input logic [31:0] a);
    logic [31:0] k = {a[31:2], 2'b00};
    if (!smem.exists(k)) smem[k] = init_val(k);
    return smem[k];
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dready_i <= 1'b0;
      drdata_i <= '0;
      lat      <= 0;
    end else if (dready_i) begin
      dready_i <= 1'b0;
    end else if (dreq_o) begin
      if (lat == 0) begin
        w_tmp = dm_get(daddr_o);
        if (dwe_o) dmem[{daddr_o[31:2], 2'b00}] = be_merge(w_tmp, dwdata_o, dbe_o);
        else drdata_i <= w_tmp;
        op_we[op_cnt % 256]   = dwe_o;
        op_addr[op_cnt % 256] = daddr_o;
        op_data[op_cnt % 256] = dwdata_o;
        op_be[op_cnt % 256]   = dbe_o;
        op_cnt = op_cnt + 1;
        dready_i <= 1'b1;
        lat <= $urandom_range(0, 3);
      end else begin
        lat <= lat - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] alias_of(input int rg, input int boff, input int k);
    return ALIAS[rg] + 32'(boff) * 32 + 32'(k) * 4;
  endfunction

  task automatic xact(input string rq, input int kind, input bit we,
                      input logic [31:0] a, input logic [31:0] wd, input logic [3:0] be,
                      input logic [3:0] mid, input logic [31:0] tgt, input int pos);
    int base;
    bit got = 1'b0;
    logic [31:0] rd, old, exp;
    logic er;
    base = op_cnt;
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = wd; be_i = be; mst_id_i = mid;
    for (int i = 0; i < 200 && !got; i++) begin
      @(negedge clk_i);
      if (ready_o) got = 1'b1;
    end
    rd = rdata_o; er = err_o;
    req_i = 1'b0;
    chk(got, rq, "ready timeout", 32'(got), 1);
    case (kind)
      K_AWR: begin
        old = sm_get(tgt);
        exp = (old & ~(32'h1 << pos)) | ({31'b0, wd[0]} << pos);
        chk(op_cnt - base == 2 && !op_we[base % 256] && op_addr[base % 256] == tgt &&
            op_be[base % 256] == 4'hF, rq, "rmw read phase", op_addr[base % 256], tgt);
        chk(op_we[(base+1) % 256] && op_addr[(base+1) % 256] == tgt &&
            op_be[(base+1) % 256] == 4'hF && op_data[(base+1) % 256] == exp,
            rq, "rmw write-back", op_data[(base+1) % 256], exp);
        chk(!er && rd == 0, rq, "alias write response", rd, 0);
        smem[{tgt[31:2], 2'b00}] = exp;
      end
      K_ARD: begin
        exp = {31'b0, sm_get(tgt)[pos]};
        chk(op_cnt - base == 1 && !op_we[base % 256] && op_addr[base % 256] == tgt,
            rq, "alias read access", op_addr[base % 256], tgt);
        chk(!er && rd == exp, rq, "alias read data", rd, exp);
      end
      K_AERR: begin
        chk(op_cnt - base == 0, rq, "no slave access on error", 32'(op_cnt - base), 0);
        chk(er && rd == 0, rq, "error response", {er, rd[30:0]}, 32'h8000_0000);
      end
      default: begin
        chk(op_cnt - base == 1 && op_we[base % 256] == we && op_addr[base % 256] == a &&
            op_be[base % 256] == be && (!we || op_data[base % 256] == wd),
            rq, "pass-through access", op_addr[base % 256], a);
        if (we) begin
          chk(!er && rd == 0, rq, "pass write response", rd, 0);
          smem[{a[31:2], 2'b00}] = be_merge(sm_get(a), wd, be);
        end else begin
          exp = sm_get(a);
          chk(!er && rd == exp, rq, "pass read data", rd, exp);
        end
      end
    endcase
    @(negedge clk_i);
    chk(!ready_o && !err_o, "R9", "ready single cycle", {31'b0, ready_o}, 0);
  endtask

  task automatic alias_op(input string rq, input int rg, input int boff, input int k,
                          input bit we, input logic [31:0] wd, input logic [3:0] mid);
    logic [31:0] tgt = BAND[rg] + (32'(boff) & ~32'h3);
    int pos = (boff % 4) * 8 + k;
    int kind = (mid != CPU) ? K_AERR : (we ? K_AWR : K_ARD);
    xact(rq, kind, we, alias_of(rg, boff, k), wd, 4'(($urandom % 16)), mid, tgt, pos);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7391));
    repeat (3) @(negedge clk_i);
    chk(!ready_o && !err_o && !dreq_o, "R1", "idle in reset", {ready_o, err_o, dreq_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!ready_o && !err_o && !dreq_o, "R1", "idle after reset", {ready_o, err_o, dreq_o}, 0);

    // directed corners
    alias_op("R2/R4 sram byte0 bit0 set", 0, 0, 0, 1'b1, 32'h0000_0001, CPU);
    alias_op("R4 upper wdata ignored", 0, 3, 7, 1'b1, 32'hFFFF_FFFE, CPU);
    alias_op("R5 read cleared bit", 0, 3, 7, 1'b0, 32'h0, CPU);
    alias_op("R5 read set bit", 0, 0, 0, 1'b0, 32'h0, CPU);
    alias_op("R3 peri write", 1, 32'h1_0002, 5, 1'b1, 32'h1, CPU);
    alias_op("R3 peri read", 1, 32'h1_0002, 5, 1'b0, 32'h0, CPU);
    alias_op("R2 last alias word", 0, (1 << 20) - 1, 7, 1'b1, 32'h0, CPU);
    alias_op("R2 last alias read", 0, (1 << 20) - 1, 7, 1'b0, 32'h0, CPU);
    alias_op("R7 dma alias write", 0, 5, 2, 1'b1, ~sm_get(BAND[0] + 4)[10] ? 32'h1 : 32'h0, DMA);
    alias_op("R7 bit unchanged", 0, 5, 2, 1'b0, 32'h0, CPU);
    alias_op("R7 dma alias read", 1, 9, 1, 1'b0, 32'h0, DMA);
    xact("R8 dma band write", K_PASS, 1'b1, BAND[0] + 32'h40, 32'hCAFE_F00D, 4'b0101, DMA, 0, 0);
    xact("R8 cpu band read", K_PASS, 1'b0, BAND[0] + 32'h40, 32'h0, 4'hF, CPU, 0, 0);
    xact("R8 other region", K_PASS, 1'b0, 32'h0800_0124, 32'h0, 4'hF, CPU, 0, 0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int sel = $urandom_range(0, 5);
      int rg  = $urandom_range(0, 1);
      int bo  = $urandom_range(0, 63);
      int k   = $urandom_range(0, 7);
      logic [3:0] mid = ($urandom_range(0, 3) == 0) ? DMA : CPU;
      logic [31:0] pa;
      case (sel)
        0, 1: alias_op(rg ? "R3/R4 rand write" : "R2/R4 rand write", rg, bo, k, 1'b1, $urandom, mid);
        2, 3: alias_op(rg ? "R3/R5 rand read" : "R2/R5 rand read", rg, bo, k, 1'b0, 32'h0, mid);
        default: begin
          pa = ((sel == 4) ? BAND[rg] : 32'h0800_0000) + (32'($urandom_range(0, 15)) << 2);
          xact("R8 rand pass", K_PASS, 1'($urandom), pa, $urandom, 4'($urandom), mid, 0, 0);
        end
      endcase
    end
    finish_run();
  end
endmodule